// File: doc/BRIEF.md
# Integer ALU with Stored Flags and Condition Test

This block performs the four integer operations of a simple register machine (add, subtract, bitwise AND, bitwise XOR) on two operands and returns the result, which is meant for the second operand's register. When an arithmetic or logic instruction is executed, the block captures three status flags from that result: zero, negative and signed overflow.

Separately, a condition selector is evaluated against the flags already held in the register. The single-bit answer drives both conditional jumps and conditional register moves. Decoding, register writeback and memory traffic stay outside the block.

Top module: `alu_cond_unit`

## Requirements
- R1: With `alu_fn_i` = 0 the result is `op_b_i + op_a_i` modulo 2^DATA_W.
- R2: With `alu_fn_i` = 1 the result is `op_b_i - op_a_i` (second operand minus first) modulo 2^DATA_W.
- R3: With `alu_fn_i` = 2 the result is the bitwise AND of the operands. With `alu_fn_i` = 3 it is the bitwise XOR.
- R4: With `alu_fn_i` in 4..15 the result is zero, and the stored flags do not change even when `set_flags_i` is high.
- R5: On a rising clock edge with `set_flags_i` high and `alu_fn_i` in 0..3, `zf_o` takes (result == 0) and `sf_o` takes the result's top bit. A value ANDed with itself therefore sets `zf_o` exactly when the value is zero.
- R6: The captured `of_o` depends on the operation. For add it is 1 when both operands share a sign and the result's sign differs from theirs. For subtract it is 1 when the operands' signs differ and the result's sign differs from `op_b_i`. For AND and XOR it is 0.
- R7: While `set_flags_i` is low, the stored flags hold their value.
- R8: While `rst_ni` is low (asynchronously), the flags read `zf_o`=1, `sf_o`=0, `of_o`=0.
- R9: `cond_true_o` is set from `cond_fn_i`, where lt = sf^of. Code 0 gives 1. Code 1 gives lt|zf. Code 2 gives lt. Code 3 gives zf. Code 4 gives !zf. Code 5 gives !lt. Code 6 gives !lt & !zf.
- R10: `cond_fn_i` codes 7..15 give `cond_true_o` = 0.
- R11: `cond_true_o` uses the stored flags, so a flag update requested in a given cycle becomes visible only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | DATA_W | First operand (source register) |
| op_b_i | input | DATA_W | Second operand (destination register) |
| alu_fn_i | input | 4 | Operation select |
| set_flags_i | input | 1 | Capture flags at the next edge |
| cond_fn_i | input | 4 | Condition select for jumps and moves |
| result_o | output | DATA_W | Operation result |
| zf_o | output | 1 | Stored zero flag |
| sf_o | output | 1 | Stored negative flag |
| of_o | output | 1 | Stored signed-overflow flag |
| cond_true_o | output | 1 | Selected condition holds |

## Verification
The bench builds the unit with DATA_W = 16. At that width the signed limits 0x7FFF, 0x8000 and 0xFFFF fit in short literals, so carry-out wrap to zero and every overflow polarity of both add and subtract can be hit directly. The logic depends on the width only through the top bit, so the same cases cover the 64-bit default. After each flag load, the bench sweeps all sixteen condition codes against the flags it predicts.

// File: rtl/alu_cond_pkg.sv
package alu_cond_pkg;

  localparam logic [3:0] FN_ADD = 4'd0;
  localparam logic [3:0] FN_SUB = 4'd1;
  localparam logic [3:0] FN_AND = 4'd2;
  localparam logic [3:0] FN_XOR = 4'd3;

  localparam logic [3:0] CC_ALWAYS = 4'd0;
  localparam logic [3:0] CC_LE     = 4'd1;
  localparam logic [3:0] CC_LT     = 4'd2;
  localparam logic [3:0] CC_EQ     = 4'd3;
  localparam logic [3:0] CC_NE     = 4'd4;
  localparam logic [3:0] CC_GE     = 4'd5;
  localparam logic [3:0] CC_GT     = 4'd6;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_cond_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [3:0]        fn_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o,
  output logic              valid_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, diff;
  logic              of_add, of_sub;

  assign sum    = op_b_i + op_a_i;
  assign diff   = op_b_i - op_a_i;
  assign of_add = (op_a_i[MSB] == op_b_i[MSB]) && (sum[MSB] != op_a_i[MSB]);
  assign of_sub = (op_a_i[MSB] != op_b_i[MSB]) && (diff[MSB] != op_b_i[MSB]);

  always_comb begin
    res_o      = '0;
    flags_o.of = 1'b0;
    valid_o    = 1'b1;
    unique case (fn_i)
      FN_ADD: begin res_o = sum;  flags_o.of = of_add; end
      FN_SUB: begin res_o = diff; flags_o.of = of_sub; end
      FN_AND: res_o = op_a_i & op_b_i;
      FN_XOR: res_o = op_a_i ^ op_b_i;
      default: valid_o = 1'b0;
    endcase
    flags_o.zf = (res_o == '0);
    flags_o.sf = res_o[MSB];
  end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_cond_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= FLAGS_RST;
    else if (load_i) q_o <= d_i;
  end

  // R7 / R4: no load, no change
  assert_flags_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import alu_cond_pkg::*;
(
  input  logic [3:0] cond_fn_i,
  input  flags_t     flags_i,
  output logic       true_o
);
  logic lt;
  assign lt = flags_i.sf ^ flags_i.of;

  always_comb begin
    unique case (cond_fn_i)
      CC_ALWAYS: true_o = 1'b1;
      CC_LE:     true_o = lt | flags_i.zf;
      CC_LT:     true_o = lt;
      CC_EQ:     true_o = flags_i.zf;
      CC_NE:     true_o = ~flags_i.zf;
      CC_GE:     true_o = ~lt;
      CC_GT:     true_o = ~lt & ~flags_i.zf;
      default:   true_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alu_cond_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [3:0]        alu_fn_i,
  input  logic              set_flags_i,
  input  logic [3:0]        cond_fn_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic              cond_true_o
);
  flags_t next_flags, cur_flags;
  logic   fn_valid;

  alu_core #(.DATA_W(DATA_W)) i_core (
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .fn_i    (alu_fn_i),
    .res_o   (result_o),
    .flags_o (next_flags),
    .valid_o (fn_valid)
  );

  flag_reg i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (set_flags_i & fn_valid),
    .d_i    (next_flags),
    .q_o    (cur_flags)
  );

  cond_eval i_cond (
    .cond_fn_i (cond_fn_i),
    .flags_i   (cur_flags),
    .true_o    (cond_true_o)
  );

  assign zf_o = cur_flags.zf;
  assign sf_o = cur_flags.sf;
  assign of_o = cur_flags.of;

  assert_bad_fn_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_fn_i > 4'd3) |-> (result_o == '0));

  assert_bad_fn_keeps_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_fn_i > 4'd3) |=> $stable({zf_o, sf_o, of_o}));

  assert_zero_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && alu_fn_i <= 4'd3) |=> (zf_o == ($past(result_o) == '0)));

  assert_logic_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && (alu_fn_i == FN_AND || alu_fn_i == FN_XOR)) |=> !of_o);

  assert_eq_tracks_zf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_fn_i == CC_EQ) |-> (cond_true_o == zf_o));

  assert_high_codes_false_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_fn_i > 4'd6) |-> !cond_true_o);

endmodule

// File: tb/test_alu_cond_unit.sv
`timescale 1ns/1ps
module test_alu_cond_unit;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   fn;
    logic [W-1:0] res;
    logic         z;
    logic         s;
    logic         o;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h0001, 16'h0002, 4'd0, 16'h0003, 1'b0, 1'b0, 1'b0},
    '{16'h0001, 16'h7FFF, 4'd0, 16'h8000, 1'b0, 1'b1, 1'b1},
    '{16'h0001, 16'hFFFF, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0},
    '{16'h8000, 16'h8000, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b1},
    '{16'h0001, 16'h0003, 4'd1, 16'h0002, 1'b0, 1'b0, 1'b0},
    '{16'h0003, 16'h0001, 4'd1, 16'hFFFE, 1'b0, 1'b1, 1'b0},
    '{16'h0001, 16'h8000, 4'd1, 16'h7FFF, 1'b0, 1'b0, 1'b1},
    '{16'hFFFF, 16'h7FFF, 4'd1, 16'h8000, 1'b0, 1'b1, 1'b1},
    '{16'h0005, 16'h0005, 4'd1, 16'h0000, 1'b1, 1'b0, 1'b0},
    '{16'hF0F0, 16'h0FF0, 4'd2, 16'h00F0, 1'b0, 1'b0, 1'b0},
    '{16'h0000, 16'h0000, 4'd2, 16'h0000, 1'b1, 1'b0, 1'b0},
    '{16'h8001, 16'h8001, 4'd2, 16'h8001, 1'b0, 1'b1, 1'b0},
    '{16'hAAAA, 16'hAAAA, 4'd3, 16'h0000, 1'b1, 1'b0, 1'b0},
    '{16'h00FF, 16'hFF00, 4'd3, 16'hFFFF, 1'b0, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a, b, res;
  logic [3:0]   fn, cfn;
  logic         setf, zf, sf, of, ct;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  alu_cond_unit #(.DATA_W(W)) i_alu_cond_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b), .alu_fn_i(fn),
    .set_flags_i(setf), .cond_fn_i(cfn), .result_o(res),
    .zf_o(zf), .sf_o(sf), .of_o(of), .cond_true_o(ct)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_cond(logic [3:0] c, logic z, logic s, logic o);
    logic lt;
    lt = s ^ o;
    case (c)
      4'd0: return 1'b1;
      4'd1: return lt | z;
      4'd2: return lt;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !lt;
      4'd6: return !lt && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep_cond(logic z, logic s, logic o);
    for (int c = 0; c < 16; c++) begin
      cfn = 4'(c);
      #0.5;
      chk(c < 7 ? $sformatf("R9 cond %0d", c) : $sformatf("R10 cond %0d", c),
          W'(ct), W'(exp_cond(4'(c), z, s, o)));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; a = '0; b = '0; fn = '0; setf = 1'b0; cfn = '0;
    repeat (2) @(negedge clk);
    chk("R8 reset flags", W'({zf, sf, of}), W'(3'b100));
    rst_n = 1'b1;
    sweep_cond(1'b1, 1'b0, 1'b0);

    // table walk: R1 add, R2 sub, R3 and/xor, R5/R6 flag capture
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a = VECS[i].a; b = VECS[i].b; fn = VECS[i].fn; setf = 1'b1;
      #1;
      chk($sformatf("%s vec %0d result",
          VECS[i].fn == 4'd0 ? "R1" : VECS[i].fn == 4'd1 ? "R2" : "R3", i),
          res, VECS[i].res);
      @(negedge clk);
      setf = 1'b0;
      chk($sformatf("R5 vec %0d zf/sf", i), W'({zf, sf}), W'({VECS[i].z, VECS[i].s}));
      chk($sformatf("R6 vec %0d of", i), W'(of), W'(VECS[i].o));
      sweep_cond(VECS[i].z, VECS[i].s, VECS[i].o);
    end

    // R4: undefined operations; stored flags are z0 s1 o0
    for (int f = 4; f < 16; f++) begin
      @(negedge clk);
      a = 16'h1234; b = 16'h4321; fn = 4'(f); setf = 1'b1;
      #1;
      chk($sformatf("R4 fn %0d result", f), res, '0);
      @(negedge clk);
      chk($sformatf("R4 fn %0d flags", f), W'({zf, sf, of}), W'(3'b010));
    end

    // R7: valid op with capture disabled
    setf = 1'b0; a = '0; b = '0; fn = 4'd0;
    repeat (2) @(negedge clk);
    chk("R7 flags held", W'({zf, sf, of}), W'(3'b010));

    // R11: update requested now is not seen until after the edge
    a = 16'h0005; b = 16'h0005; fn = 4'd3; setf = 1'b1; cfn = 4'd3;
    #1;
    chk("R11 eq before edge", W'(ct), W'(1'b0));
    @(negedge clk);
    setf = 1'b0;
    chk("R11 eq after edge", W'(ct), W'(1'b1));

    // R8: asynchronous reset mid-run
    a = 16'h0003; b = 16'h0001; fn = 4'd1; setf = 1'b1;
    @(negedge clk);
    setf = 1'b0;
    chk("R8 pre-reset flags", W'({zf, sf, of}), W'(3'b010));
    rst_n = 1'b0;
    #1;
    chk("R8 async reset flags", W'({zf, sf, of}), W'(3'b100));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule